// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block holds eight small control registers, each tied to one active-low chip-select output for external memory. Software programs a register through a simple register bus. A register selects which bus area the select answers to (area 0 or area 2), how large the connected memory is, and where its window starts. The block then compares the upper address bits of every bus access against each programmed window. It pulls the matching chip-selects low for as long as the access lasts.

The window size ranges from 4 MB (a 32 Mbit device) to 32 MB (a 256 Mbit device). A larger size ignores more of the low start-address bits, so the comparison gets coarser as the size grows. The area enables come from the bus controller's own area decode, and the access strobe marks a live access.

There are two resets. A power-on reset clears every register. A manual reset leaves the contents untouched. Windows may overlap, and every select that matches asserts at once.

Top module: `memsel_decoder`

## Requirements
- R1: A write (reg_wr high) to register reg_idx is stored at the next rising clock edge. reg_rdata combinationally returns the stored value of the register that reg_idx currently addresses.
- R2: Bits 15:7 of every register read back as 0, and any value written to those bits is discarded.
- R3: Bit 6 of a register picks the area: 0 ties the select to area0_en and 1 ties it to area2_en. A select never asserts while its chosen area enable is low.
- R4: Bits 5:4 give the size code, which sets which start bits take part in the compare. Code 0 compares bus_addr_hi[3:0], code 1 compares [3:1], code 2 compares [3:2] and code 3 compares [3] only. The start bits left out are ignored.
- R5: Bits 3:0 hold the window start, with bit 3 matching bus_addr_hi[3] (A25) down to bit 0 matching bus_addr_hi[0] (A22).
- R6: While por_rst is high at a rising edge, every register becomes 0x0000. This takes priority over a write in the same cycle.
- R7: man_rst never changes register contents. A write made while man_rst is high is dropped.
- R8: Register 0 keeps bit 6 at 0 whatever is written, so select 0 only ever answers to area 0.
- R9: sel_n[i] is 0 exactly when bus_strobe is high, the chosen area enable is high and the masked address matches. Otherwise it is 1, which includes every select whenever bus_strobe is low.
- R10: When several windows match the same access, all of their selects go low together, with no priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset, clears the registers |
| man_rst | input | 1 | Active-high manual reset, keeps the registers and blocks writes |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for the read and the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of register reg_idx |
| bus_addr_hi | input | 4 | Bus address bits A25:A22 |
| bus_strobe | input | 1 | Bus access in progress |
| area0_en | input | 1 | Bus controller decodes area 0 |
| area2_en | input | 1 | Bus controller decodes area 2 |
| sel_n | output | 8 | Active-low chip-selects, one per register |

## Verification
A register write becomes visible one rising edge after the strobe is sampled. The bench therefore drives a write at a falling edge and reads it back at the following falling edge, after the capturing rising edge has passed. Reads and chip-select decode are combinational from the inputs and the stored registers. The bench changes those inputs at a falling edge and samples one time unit later, inside the same low clock phase. Both resets act at the rising edge, so their effects are checked in the next low phase.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    localparam int REG_W   = 16;
    localparam int START_W = 4;
    localparam int SIZE_W  = 2;

    // Writable field mask: area bit, size code, start bits.
    localparam logic [REG_W-1:0] RW_MASK   = 16'h007F;
    localparam int               AREA_BIT  = 6;
    localparam logic [REG_W-1:0] AREA_MASK = 16'h0040;

    typedef struct packed {
        logic               area2;
        logic [SIZE_W-1:0]  size;
        logic [START_W-1:0] start;
    } ctrl_t;

    function automatic ctrl_t to_ctrl(input logic [REG_W-1:0] raw);
        ctrl_t c;
        c.area2 = raw[AREA_BIT];
        c.size  = raw[5:4];
        c.start = raw[3:0];
        return c;
    endfunction

    // Larger size code drops more low start bits from the compare.
    function automatic logic [START_W-1:0] win_mask(input logic [SIZE_W-1:0] code);
        logic [START_W-1:0] m;
        m = {START_W{1'b1}} << code;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] lane_mask(input int lane);
        logic [REG_W-1:0] m;
        m = RW_MASK;
        if (lane == 0) begin
            m = RW_MASK & ~AREA_MASK;
        end
        return m;
    endfunction

endpackage

// File: rtl/memsel_regbank.sv
module memsel_regbank
    import memsel_pkg::*;
#(
    parameter int NUM_SEL = 8,
    localparam int IDX_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
    input  logic                     clk,
    input  logic                     por_rst,
    input  logic                     man_rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         idx,
    input  logic [REG_W-1:0]         wr_data,
    output logic [REG_W-1:0]         rd_data,
    output ctrl_t                    cfg_o [NUM_SEL],
    output logic [NUM_SEL*REG_W-1:0] raw_o
);

    logic [REG_W-1:0] regs_q [NUM_SEL];

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_lane
        localparam logic [REG_W-1:0] KEEP = lane_mask(i);
        logic hit_w;

        assign hit_w = wr_en && !man_rst && (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (por_rst) begin
                regs_q[i] <= '0;
            end else if (hit_w) begin
                regs_q[i] <= wr_data & KEEP;
            end
        end

        assign cfg_o[i]                  = to_ctrl(regs_q[i]);
        assign raw_o[i*REG_W +: REG_W]   = regs_q[i];
    end

    assign rd_data = regs_q[idx];

endmodule

// File: rtl/memsel_window.sv
module memsel_window
    import memsel_pkg::*;
(
    input  ctrl_t               cfg,
    input  logic [START_W-1:0]  addr_hi,
    input  logic                strobe,
    input  logic                area0_en,
    input  logic                area2_en,
    output logic                hit
);

    logic [START_W-1:0] mask_w;
    logic               area_ok;
    logic               addr_ok;

    always_comb begin
        mask_w  = win_mask(cfg.size);
        area_ok = cfg.area2 ? area2_en : area0_en;
        addr_ok = ((addr_hi ^ cfg.start) & mask_w) == '0;
        hit     = strobe && area_ok && addr_ok;
    end

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int NUM_SEL = 8,
    localparam int IDX_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
    input  logic                 clk,
    input  logic                 por_rst,
    input  logic                 man_rst,
    input  logic                 reg_wr,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [START_W-1:0]   bus_addr_hi,
    input  logic                 bus_strobe,
    input  logic                 area0_en,
    input  logic                 area2_en,
    output logic [NUM_SEL-1:0]   sel_n
);

    ctrl_t                    cfg_w [NUM_SEL];
    logic [NUM_SEL*REG_W-1:0] cfg_flat;
    logic [NUM_SEL-1:0]       hit_w;

    memsel_regbank #(.NUM_SEL(NUM_SEL)) bank_i (
        .clk     (clk),
        .por_rst (por_rst),
        .man_rst (man_rst),
        .wr_en   (reg_wr),
        .idx     (reg_idx),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .cfg_o   (cfg_w),
        .raw_o   (cfg_flat)
    );

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_win
        memsel_window win_i (
            .cfg      (cfg_w[i]),
            .addr_hi  (bus_addr_hi),
            .strobe   (bus_strobe),
            .area0_en (area0_en),
            .area2_en (area2_en),
            .hit      (hit_w[i])
        );
    end

    // No priority: every matching window drives its select.
    assign sel_n = ~hit_w;

endmodule

// File: rtl/memsel_chk.sv
module memsel_chk
    import memsel_pkg::*;
#(
    parameter int NUM_SEL = 8
) (
    input logic                     clk,
    input logic                     por_rst,
    input logic                     man_rst,
    input logic                     bus_strobe,
    input logic                     area0_en,
    input logic                     area2_en,
    input logic [REG_W-1:0]         reg_rdata,
    input logic [NUM_SEL-1:0]       sel_n,
    input logic [NUM_SEL*REG_W-1:0] cfg_flat
);

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R6
    por_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        por_rst |=> (cfg_flat == '0));

    // R7
    man_hold_chk: assert property (@(posedge clk) disable iff (!armed || por_rst)
        (man_rst && !por_rst) |=> $stable(cfg_flat));

    // R2
    resv_zero_chk: assert property (@(posedge clk) disable iff (!armed || por_rst)
        reg_rdata[REG_W-1:7] == '0);

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!armed || por_rst)
        !bus_strobe |-> (&sel_n));

    // R3
    no_area_chk: assert property (@(posedge clk) disable iff (!armed || por_rst)
        (!area0_en && !area2_en) |-> (&sel_n));

    // R8
    sel0_area0_chk: assert property (@(posedge clk) disable iff (!armed || por_rst)
        !area0_en |-> sel_n[0]);

endmodule

bind memsel_decoder memsel_chk #(.NUM_SEL(NUM_SEL)) chk_i (
    .clk        (clk),
    .por_rst    (por_rst),
    .man_rst    (man_rst),
    .bus_strobe (bus_strobe),
    .area0_en   (area0_en),
    .area2_en   (area2_en),
    .reg_rdata  (reg_rdata),
    .sel_n      (sel_n),
    .cfg_flat   (cfg_flat)
);

// File: tb/memsel_decoder_tb.sv
module memsel_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSEL       = 8;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        man_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  bus_addr_hi = '0;
    logic        bus_strobe = 1'b0;
    logic        area0_en = 1'b0;
    logic        area2_en = 1'b0;
    logic [7:0]  sel_n;

    logic [15:0] mdl [NSEL];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memsel_decoder #(.NUM_SEL(NSEL)) dut_i (
        .clk, .por_rst, .man_rst, .reg_wr, .reg_idx, .reg_wdata, .reg_rdata,
        .bus_addr_hi, .bus_strobe, .area0_en, .area2_en, .sel_n
    );

    function automatic logic [15:0] keep_bits(input int i, input logic [15:0] d);
        return (i == 0) ? (d & 16'h003F) : (d & 16'h007F);
    endfunction

    function automatic logic [7:0] exp_sel(input logic [3:0] a, input logic s,
                                           input logic e0, input logic e2);
        logic [7:0] r;
        for (int i = 0; i < NSEL; i++) begin
            logic [3:0] m;
            logic       ar;
            m  = 4'hF << mdl[i][5:4];
            ar = mdl[i][6] ? e2 : e0;
            r[i] = ~(s && ar && (((a ^ mdl[i][3:0]) & m) == 4'h0));
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int i, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 3'(i); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (!man_rst) mdl[i] = keep_bits(i, d);
    endtask

    task automatic rd_chk(input int i, input string tag);
        reg_idx = 3'(i);
        #1;
        check(reg_rdata === mdl[i], tag, reg_rdata, mdl[i]);
    endtask

    task automatic dec_chk(input logic [3:0] a, input logic s, input logic e0,
                           input logic e2, input string tag);
        logic [7:0] e;
        @(negedge clk);
        bus_addr_hi = a; bus_strobe = s; area0_en = e0; area2_en = e2;
        #1;
        e = exp_sel(a, s, e0, e2);
        check(sel_n === e, tag, {8'h00, sel_n}, {8'h00, e});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NSEL; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        por_rst = 1'b0;

        // R6 reset state, R9 idle selects high
        for (int i = 0; i < NSEL; i++) rd_chk(i, "R6 reset value");
        dec_chk(4'h0, 1'b0, 1'b1, 1'b1, "R9 idle all high");

        // R1 and R2: write/read, reserved discarded
        wr(1, 16'h0005);
        rd_chk(1, "R1 readback");
        wr(2, 16'hFFFF);
        rd_chk(2, "R2 reserved masked");
        // R8: register 0 area bit stays 0
        wr(0, 16'h0073);
        rd_chk(0, "R8 area bit forced 0");
        dec_chk(4'h3, 1'b1, 1'b0, 1'b1, "R8 sel0 ignores area2");

        // R5 start bit order: only A22 set
        wr(4, 16'h0001);
        dec_chk(4'h1, 1'b1, 1'b1, 1'b0, "R5 start A22 hit");
        dec_chk(4'h8, 1'b1, 1'b1, 1'b0, "R5 start A25 miss");
        check(sel_n[4] === 1'b1, "R5 ch4 off for 0x8", {15'h0, sel_n[4]}, 16'h1);

        // R4 size code: code 3 compares A25 only
        wr(3, 16'h0038);
        dec_chk(4'hF, 1'b1, 1'b1, 1'b0, "R4 size3 hit high");
        check(sel_n[3] === 1'b0, "R4 ch3 low at 0xF", {15'h0, sel_n[3]}, 16'h0);
        dec_chk(4'h7, 1'b1, 1'b1, 1'b0, "R4 size3 miss low");
        check(sel_n[3] === 1'b1, "R4 ch3 high at 0x7", {15'h0, sel_n[3]}, 16'h1);
        wr(3, 16'h0016);
        dec_chk(4'h7, 1'b1, 1'b1, 1'b0, "R4 size1 ignores A22");

        // R3 area selection
        wr(5, 16'h0070);
        dec_chk(4'h2, 1'b1, 1'b1, 1'b0, "R3 area2 window, area0 active");
        check(sel_n[5] === 1'b1, "R3 ch5 off", {15'h0, sel_n[5]}, 16'h1);
        dec_chk(4'h2, 1'b1, 1'b0, 1'b1, "R3 area2 window, area2 active");
        check(sel_n[5] === 1'b0, "R3 ch5 on", {15'h0, sel_n[5]}, 16'h0);

        // R10 overlap: configuration case, both assert
        wr(6, 16'h0005);
        dec_chk(4'h5, 1'b1, 1'b1, 1'b0, "R10 overlap");
        check(sel_n[1] === 1'b0 && sel_n[6] === 1'b0, "R10 both low",
              {8'h0, sel_n}, {8'h0, 8'hBD & exp_sel(4'h5, 1'b1, 1'b1, 1'b0)});
        $display("note: windows 1 and 6 overlap (configuration case)");

        // R7 manual reset keeps contents and drops writes
        @(negedge clk); man_rst = 1'b1;
        wr(1, 16'h002A);
        @(negedge clk);
        for (int i = 0; i < NSEL; i++) rd_chk(i, "R7 held over manual reset");
        man_rst = 1'b0;
        rd_chk(1, "R7 after release");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k < 3) begin
                man_rst = ($urandom_range(0, 5) == 0);
                wr(int'($urandom_range(0, 7)), 16'($urandom));
                man_rst = 1'b0;
                rd_chk(int'($urandom_range(0, 7)), "R1 R2 R7 random readback");
            end else begin
                dec_chk(4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        "R3 R4 R5 R9 random decode");
            end
        end

        // R6: power-on reset wins over a simultaneous write
        @(negedge clk);
        por_rst = 1'b1; reg_wr = 1'b1; reg_idx = 3'd2; reg_wdata = 16'h007F;
        @(negedge clk);
        por_rst = 1'b0; reg_wr = 1'b0;
        for (int i = 0; i < NSEL; i++) mdl[i] = '0;
        for (int i = 0; i < NSEL; i++) rd_chk(i, "R6 por over write");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule